// File: doc/BRIEF.md
# Byte/Word Memory Alignment Unit

This combinational unit sits between a 16-bit register bus, the memory data register and a byte-addressable memory that is organised as 16-bit words. It has three jobs.

On a load, it either passes the whole fetched word to the bus, or it picks one byte of that word by the address least significant bit and sign-extends it. On a store, it builds the data word for the memory data register. For a byte store, it copies the low byte of the source register into both halves, so the byte is present in either lane.

The lane that is actually written is chosen only by the two byte-lane write enables, which the unit also drives. A write enable is raised only during a requested memory write. A word access at an odd address raises a flag and blocks both enables.

Top module: `mem_align_unit`

## Requirements
- R1: A byte load (size_word=0) with addr_lsb=0 drives load_bus with mdr_q[7:0] sign-extended to 16 bits.
- R2: A byte load with addr_lsb=1 drives load_bus with mdr_q[15:8] sign-extended to 16 bits.
- R3: A word load (size_word=1) drives load_bus with mdr_q unchanged.
- R4: store_mdr equals {src_reg[7:0], src_reg[7:0]} when size_word=0 and src_reg when size_word=1.
- R5: A byte write (mem_cyc_en=1, wr_not_rd=1, size_word=0) raises only we_lo when addr_lsb=0 and only we_hi when addr_lsb=1. we_hi enables memory bits [15:8] and we_lo enables bits [7:0].
- R6: A word write with addr_lsb=0 raises both we_hi and we_lo.
- R7: With wr_not_rd=0 (read), neither write enable is raised.
- R8: With mem_cyc_en=0, neither write enable nor misalign is raised, whatever the other inputs are.
- R9: With mem_cyc_en=1, size_word=1 and addr_lsb=1, misalign is raised and neither write enable is raised. A byte access never raises misalign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdr_q | input | 16 | Current memory data register contents |
| src_reg | input | 16 | Source register value for stores |
| addr_lsb | input | 1 | Bit 0 of the memory address register |
| size_word | input | 1 | 1 = word access, 0 = byte access |
| wr_not_rd | input | 1 | 1 = write, 0 = read |
| mem_cyc_en | input | 1 | A memory or I/O cycle is requested |
| load_bus | output | 16 | Load data gated to the bus |
| store_mdr | output | 16 | Store data for the memory data register input |
| we_hi | output | 1 | Write enable for bits [15:8] |
| we_lo | output | 1 | Write enable for bits [7:0] |
| misalign | output | 1 | Word access at odd address |

## Verification
The bench loads bytes with the sign bit set and clear from each lane. A unit that selected the wrong lane, or that zero-extended instead of sign-extending, would return a bus value with the wrong low byte or wrong upper bits.

It writes bytes at both address parities. A unit with swapped enables would raise we_hi for an even address, and a unit that did not gate the enables would write during reads or idle cycles.

It also issues word writes at an odd address. A unit that ignored the alignment flag would still raise an enable there.

// File: rtl/align_pkg.sv
// Shared definitions for the memory alignment unit.
// Assumes a memory word made of exactly two byte lanes.
package align_pkg;
    localparam int unsigned LANES = 2;
    typedef enum logic {SZ_BYTE = 1'b0, SZ_WORD = 1'b1} acc_size_e;
endpackage

// File: rtl/load_extract.sv
// Load path: picks the byte addressed by the LSB and sign-extends it,
// or passes the full word. Assumes DATA_W is even.
module load_extract #(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] word_in,
    input  logic              lsb,
    input  logic              is_word,
    output logic [DATA_W-1:0] bus_out
);
    localparam int unsigned BYTE_W = DATA_W / 2;

    logic [BYTE_W-1:0] lane_byte;

    // Choose the byte lane from the address LSB.
    always_comb begin
        lane_byte = lsb ? word_in[DATA_W-1:BYTE_W] : word_in[BYTE_W-1:0];
    end

    // Width select between sign-extended byte and full word.
    always_comb begin
        if (is_word == align_pkg::SZ_WORD)
            bus_out = word_in;
        else
            bus_out = {{BYTE_W{lane_byte[BYTE_W-1]}}, lane_byte};
    end

    // R1/R2: a byte result has its whole upper half equal to the byte sign.
    always_comb begin
        if (!is_word)
            a_r1_byte_sext: assert ($countones(bus_out[DATA_W-1:BYTE_W-1]) == 0 ||
                                    $countones(bus_out[DATA_W-1:BYTE_W-1]) == BYTE_W + 1);
    end
endmodule

// File: rtl/store_replicate.sv
// Store path: replicates the low source byte into both halves for byte
// stores, passes the source word for word stores.
module store_replicate #(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] src,
    input  logic              is_word,
    output logic [DATA_W-1:0] store_out
);
    localparam int unsigned BYTE_W = DATA_W / 2;

    // Build the store word for the data register.
    always_comb begin
        if (is_word == align_pkg::SZ_WORD)
            store_out = src;
        else
            store_out = {align_pkg::LANES{src[BYTE_W-1:0]}};
    end

    // R4: byte store data carries identical halves.
    always_comb begin
        if (!is_word)
            a_r4_halves_equal: assert (store_out[DATA_W-1:BYTE_W] == store_out[BYTE_W-1:0]);
    end
endmodule

// File: rtl/lane_enable.sv
// Byte-lane write enable generation and misalignment flag.
// Assumes only a word access at an odd address is misaligned.
module lane_enable (
    input  logic lsb,
    input  logic is_word,
    input  logic is_write,
    input  logic cyc_en,
    output logic en_hi,
    output logic en_lo,
    output logic bad_align
);
    logic wr_cyc;

    // Qualify the write request with the memory cycle enable.
    always_comb begin
        wr_cyc    = cyc_en & is_write;
        bad_align = cyc_en & is_word & lsb;
    end

    // Decode the lanes to write.
    always_comb begin
        en_hi = 1'b0;
        en_lo = 1'b0;
        if (wr_cyc && !bad_align) begin
            if (is_word) begin
                en_hi = 1'b1;
                en_lo = 1'b1;
            end else begin
                en_hi = lsb;
                en_lo = ~lsb;
            end
        end
    end

    // Guard the enable outputs against the request inputs.
    always_comb begin
        if (!is_write || !cyc_en)
            a_r7_r8_no_write: assert (!en_hi && !en_lo);
        if (!is_word)
            a_r5_single_lane: assert (!(en_hi && en_lo));
        if (bad_align)
            a_r9_blocked: assert (!en_hi && !en_lo);
        if (!cyc_en)
            a_r8_no_flag: assert (!bad_align);
    end
endmodule

// File: rtl/mem_align_unit.sv
// Top of the alignment unit: load extraction, store replication and
// byte-lane write enables. Purely combinational.
module mem_align_unit #(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] mdr_q,
    input  logic [DATA_W-1:0] src_reg,
    input  logic              addr_lsb,
    input  logic              size_word,
    input  logic              wr_not_rd,
    input  logic              mem_cyc_en,
    output logic [DATA_W-1:0] load_bus,
    output logic [DATA_W-1:0] store_mdr,
    output logic              we_hi,
    output logic              we_lo,
    output logic              misalign
);
    load_extract #(.DATA_W(DATA_W)) u_load (
        .word_in (mdr_q),
        .lsb     (addr_lsb),
        .is_word (size_word),
        .bus_out (load_bus)
    );

    store_replicate #(.DATA_W(DATA_W)) u_store (
        .src       (src_reg),
        .is_word   (size_word),
        .store_out (store_mdr)
    );

    lane_enable u_we (
        .lsb       (addr_lsb),
        .is_word   (size_word),
        .is_write  (wr_not_rd),
        .cyc_en    (mem_cyc_en),
        .en_hi     (we_hi),
        .en_lo     (we_lo),
        .bad_align (misalign)
    );

    // R6: aligned word write reaches both lanes.
    always_comb begin
        if (mem_cyc_en && wr_not_rd && size_word && !addr_lsb)
            a_r6_word_both: assert (we_hi && we_lo);
    end
endmodule

// File: tb/mem_align_unit_tb.sv
module mem_align_unit_tb_top;
    logic        clk = 1'b0;
    logic [15:0] mdr_q = '0, src_reg = '0;
    logic        addr_lsb = 1'b0, size_word = 1'b0, wr_not_rd = 1'b0, mem_cyc_en = 1'b0;
    logic [15:0] load_bus, store_mdr;
    logic        we_hi, we_lo, misalign;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    mem_align_unit dut_i (
        .mdr_q(mdr_q), .src_reg(src_reg), .addr_lsb(addr_lsb), .size_word(size_word),
        .wr_not_rd(wr_not_rd), .mem_cyc_en(mem_cyc_en), .load_bus(load_bus),
        .store_mdr(store_mdr), .we_hi(we_hi), .we_lo(we_lo), .misalign(misalign)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic l, input logic w, input logic wr, input logic en);
        @(posedge clk);
        addr_lsb = l; size_word = w; wr_not_rd = wr; mem_cyc_en = en;
        @(negedge clk);
    endtask

    task automatic t_idle();
        mdr_q = 16'h1234; src_reg = 16'hABCD;
        apply(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R8 idle enables", {14'd0, we_hi, we_lo}, 16'd0);
        chk("R8 idle flag", {15'd0, misalign}, 16'd0);
        apply(1'b1, 1'b1, 1'b1, 1'b0);
        chk("R8 idle odd word", {13'd0, misalign, we_hi, we_lo}, 16'd0);
    endtask

    task automatic t_byte_load();
        mdr_q = 16'h7F85;
        apply(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R1 neg low byte", load_bus, 16'hFF85);
        apply(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R2 pos high byte", load_bus, 16'h007F);
        mdr_q = 16'h9A42;
        apply(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R1 pos low byte", load_bus, 16'h0042);
        apply(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R2 neg high byte", load_bus, 16'hFF9A);
        chk("R9 byte no flag", {15'd0, misalign}, 16'd0);
    endtask

    task automatic t_word_load();
        mdr_q = 16'h9A42;
        apply(1'b0, 1'b1, 1'b0, 1'b1);
        chk("R3 word load", load_bus, 16'h9A42);
        chk("R7 read no enables", {14'd0, we_hi, we_lo}, 16'd0);
    endtask

    task automatic t_store_data();
        src_reg = 16'hC3A5;
        apply(1'b1, 1'b0, 1'b1, 1'b1);
        chk("R4 byte store", store_mdr, 16'hA5A5);
        apply(1'b0, 1'b1, 1'b1, 1'b1);
        chk("R4 word store", store_mdr, 16'hC3A5);
    endtask

    task automatic t_enables();
        apply(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R5 byte even", {14'd0, we_hi, we_lo}, 16'b01);
        apply(1'b1, 1'b0, 1'b1, 1'b1);
        chk("R5 byte odd", {14'd0, we_hi, we_lo}, 16'b10);
        apply(1'b0, 1'b1, 1'b1, 1'b1);
        chk("R6 word aligned", {14'd0, we_hi, we_lo}, 16'b11);
        apply(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R7 byte read", {14'd0, we_hi, we_lo}, 16'd0);
    endtask

    task automatic t_misalign();
        apply(1'b1, 1'b1, 1'b1, 1'b1);
        chk("R9 odd word write", {13'd0, misalign, we_hi, we_lo}, 16'b100);
        apply(1'b1, 1'b1, 1'b0, 1'b1);
        chk("R9 odd word read", {13'd0, misalign, we_hi, we_lo}, 16'b100);
    endtask

    initial begin
        t_idle();
        t_byte_load();
        t_word_load();
        t_store_data();
        t_enables();
        t_misalign();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog act=hung exp=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule